// File: doc/BRIEF.md
# Link Communication-Loss Watchdog

This block supervises a host serial link. It measures time, in timebase ticks, since the last transaction that was really meant for this device. If that time runs past a programmed limit, it moves the device from its normal operating state into a fail-safe state and raises a sticky flag. The serial decoder is outside the block. The block sees only a per-transaction completion pulse and three status bits: CRC good, address matched, and broadcast.

A 4-bit timeout code selects the behaviour:

- Code 0 turns supervision off.
- Code 15 sends the device to fail-safe at once.
- Codes 1 to 14 give a limit of code × `TICKS_PER_STEP` timebase ticks.

The host leaves fail-safe by pulsing a clear write. That write also drops the flag and restarts the count. Any change of the timeout code also restarts the count.

Top module: `link_watchdog`

## Requirements
- R1: A transaction counts as qualifying when `txn_done`=1, `txn_crc_ok`=1, `txn_addr_hit`=1 and `txn_bcast`=0 in the same cycle. A qualifying transaction sets the elapsed count back to zero. If it arrives in the same cycle as a tick, the tick is discarded.
- R2: A completed transaction with a bad CRC, a missing address match, or the broadcast bit set leaves the elapsed count untouched.
- R3: A `clr_fs_wr` pulse has three effects at the next edge: the state becomes normal (`fail_safe`=0), `fs_flag` becomes 0, and the count restarts.
- R4: For codes 1 to 14 with no qualifying transaction, restart or code change, the tick that brings the count to code × `TICKS_PER_STEP` changes the outputs at the next edge: `fail_safe`=1 and `fs_flag`=1. Both then hold until a clear.
- R5: While the code is 0, no number of ticks moves the device out of the normal state.
- R6: While the code is 15 and in the normal state, the next edge enters fail-safe. A clear while the code stays 15 gives exactly one cycle of normal state, then fail-safe again.
- R7: A change of `timeout_code` restarts the elapsed count from zero.
- R8: After reset `fail_safe`=0 and `fs_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_done | input | 1 | One-cycle pulse when a link transaction completes |
| txn_crc_ok | input | 1 | Transaction CRC was correct |
| txn_addr_hit | input | 1 | Transaction address matched this device |
| txn_bcast | input | 1 | Transaction was a broadcast |
| timeout_code | input | 4 | Timeout setting: 0 off, 1..14 scaled, 15 immediate |
| clr_fs_wr | input | 1 | Clear-fail-safe write pulse |
| tb_tick | input | 1 | Timebase tick, one cycle wide |
| fail_safe | output | 1 | 1 while in fail-safe state |
| fs_flag | output | 1 | Sticky fail-safe flag |

## Verification
The expiry path is run with an idle link and with a qualifying transaction mid-window. Comparing the two shows that a qualifying transaction restarts the window rather than merely pausing it. Each non-qualifying pattern (bad CRC, address miss, broadcast) is sent partway through a window; the expected expiry tick stays unchanged, which tells a filtered transaction from a restarting one. A code change mid-window, a kick coinciding with a tick, code 0 under long tick trains, and code 15 with a clear held against it separate the restart sources and the two special codes.

// File: rtl/link_wd_pkg.sv
package link_wd_pkg;
    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] CODE_OFF  = '0;
    localparam logic [CODE_W-1:0] CODE_NOW  = '1;

    typedef enum logic {
        ST_NORMAL   = 1'b0,
        ST_FAILSAFE = 1'b1
    } wd_state_e;

    typedef struct packed {
        wd_state_e state;
        logic      flag;
    } mode_regs_t;
endpackage

// File: rtl/link_wd_qual.sv
module link_wd_qual (
    input  logic txn_done,
    input  logic crc_ok,
    input  logic addr_hit,
    input  logic bcast,
    output logic kick
);
    always_comb begin
        kick = txn_done & crc_ok & addr_hit & ~bcast;
    end
endmodule

// File: rtl/link_wd_timer.sv
module link_wd_timer
    import link_wd_pkg::*;
#(
    parameter int TICKS_PER_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              kick,
    input  logic              clr,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              expire
);
    localparam int MAX_LIMIT = 14 * TICKS_PER_STEP;
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(TICKS_PER_STEP);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  count;
    } timer_regs_t;

    timer_regs_t       r_q, r_d;
    logic [CNT_W-1:0]  limit;
    logic              scaled;
    logic              restart;

    always_comb begin
        limit   = CNT_W'(code) * STEP;
        scaled  = (code != CODE_OFF) && (code != CODE_NOW);
        restart = kick | clr | !run | (code != r_q.code);
        expire  = run && scaled && tick && !restart && (r_q.count == limit - 1'b1);

        r_d      = r_q;
        r_d.code = code;
        if (restart || expire || !scaled) begin
            r_d.count = '0;
        end else if (tick) begin
            r_d.count = r_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.code != CODE_OFF && r_q.code != CODE_NOW) |->
            (r_q.count < CNT_W'(r_q.code) * STEP)) else $error("count past limit"); // R4

    AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (r_q.count == '0)) else $error("kick did not restart"); // R1

    AST_CODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (code != r_q.code) |=> (r_q.count == '0)) else $error("code change did not restart"); // R7
endmodule

// File: rtl/link_wd_mode.sv
module link_wd_mode
    import link_wd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              expire,
    input  logic [CODE_W-1:0] code,
    output logic              run,
    output logic              fail_safe,
    output logic              flag
);
    mode_regs_t m_q, m_d;

    always_comb begin
        m_d = m_q;
        if (clr) begin
            m_d.state = ST_NORMAL;
            m_d.flag  = 1'b0;
        end else if (m_q.state == ST_NORMAL && (expire || code == CODE_NOW)) begin
            m_d.state = ST_FAILSAFE;
            m_d.flag  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{state: ST_NORMAL, flag: 1'b0};
        end else begin
            m_q <= m_d;
        end
    end

    always_comb begin
        run       = (m_q.state == ST_NORMAL);
        fail_safe = (m_q.state == ST_FAILSAFE);
        flag      = m_q.flag;
    end

    AST_CLR_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!fail_safe && !flag)) else $error("clear ignored"); // R3

    AST_FS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_safe && !clr) |=> (fail_safe && flag)) else $error("fail-safe left"); // R4

    AST_OFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fail_safe && code == CODE_OFF && !clr) |=> !fail_safe) else $error("code 0 tripped"); // R5

    AST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fail_safe && code == CODE_NOW && !clr) |=> (fail_safe && flag)) else $error("code 15 late"); // R6
endmodule

// File: rtl/link_watchdog.sv
module link_watchdog
    import link_wd_pkg::*;
#(
    parameter int TICKS_PER_STEP = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        txn_done,
    input  logic        txn_crc_ok,
    input  logic        txn_addr_hit,
    input  logic        txn_bcast,
    input  logic [3:0]  timeout_code,
    input  logic        clr_fs_wr,
    input  logic        tb_tick,
    output logic        fail_safe,
    output logic        fs_flag
);
    logic kick;
    logic run;
    logic expire;

    link_wd_qual u_qual (
        .txn_done (txn_done),
        .crc_ok   (txn_crc_ok),
        .addr_hit (txn_addr_hit),
        .bcast    (txn_bcast),
        .kick     (kick)
    );

    link_wd_timer #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .kick   (kick),
        .clr    (clr_fs_wr),
        .tick   (tb_tick),
        .code   (timeout_code),
        .expire (expire)
    );

    link_wd_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_fs_wr),
        .expire    (expire),
        .code      (timeout_code),
        .run       (run),
        .fail_safe (fail_safe),
        .flag      (fs_flag)
    );

    AST_RESET_NORMAL: assert property (@(posedge clk)
        $rose(rst_n) |-> (!fail_safe && !fs_flag)) else $error("reset state"); // R8
endmodule

// File: tb/link_watchdog_tb_top.sv
module link_watchdog_tb_top;
    localparam int STEP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_done = 1'b0, txn_crc_ok = 1'b0, txn_addr_hit = 1'b0, txn_bcast = 1'b0;
    logic [3:0] timeout_code = 4'd0;
    logic       clr_fs_wr = 1'b0;
    logic       tb_tick = 1'b0;
    logic       fail_safe, fs_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    link_watchdog #(.TICKS_PER_STEP(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .txn_done(txn_done), .txn_crc_ok(txn_crc_ok),
        .txn_addr_hit(txn_addr_hit), .txn_bcast(txn_bcast),
        .timeout_code(timeout_code), .clr_fs_wr(clr_fs_wr),
        .tb_tick(tb_tick), .fail_safe(fail_safe), .fs_flag(fs_flag)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic fs_exp, input logic flag_exp);
        n_tests++;
        if (fail_safe !== fs_exp || fs_flag !== flag_exp) begin
            n_fail++;
            $display("FAIL %s: fail_safe=%b fs_flag=%b expected %b %b",
                     req, fail_safe, fs_flag, fs_exp, flag_exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tb_tick = 1'b1; step(); tb_tick = 1'b0; step();
        end
    endtask

    task automatic txn(input logic crc, input logic hit, input logic bc);
        txn_done = 1'b1; txn_crc_ok = crc; txn_addr_hit = hit; txn_bcast = bc;
        step();
        txn_done = 1'b0; txn_crc_ok = 1'b0; txn_addr_hit = 1'b0; txn_bcast = 1'b0;
    endtask

    task automatic clear();
        clr_fs_wr = 1'b1; step(); clr_fs_wr = 1'b0; step();
    endtask

    task automatic t_reset();
        check("R8 reset", 1'b0, 1'b0);
    endtask

    task automatic t_expire();
        timeout_code = 4'd2; step(); clear();
        ticks(2 * STEP - 1);
        check("R4 before limit", 1'b0, 1'b0);
        ticks(1);
        check("R4 at limit", 1'b1, 1'b1);
        ticks(3); step();
        check("R4 sticky", 1'b1, 1'b1);
        clear();
        check("R3 clear", 1'b0, 1'b0);
        ticks(2 * STEP - 1);
        check("R3 clear restarts", 1'b0, 1'b0);
        ticks(1);
        check("R3 expiry after clear", 1'b1, 1'b1);
        clear();
    endtask

    task automatic t_kick();
        ticks(5);
        txn(1'b1, 1'b1, 1'b0);
        ticks(2 * STEP - 1);
        check("R1 kick restarts", 1'b0, 1'b0);
        ticks(1);
        check("R1 expiry after kick", 1'b1, 1'b1);
        clear();
        ticks(2 * STEP - 1);
        // R1: kick coincident with the tick that would expire
        tb_tick = 1'b1; txn_done = 1'b1; txn_crc_ok = 1'b1; txn_addr_hit = 1'b1;
        step();
        tb_tick = 1'b0; txn_done = 1'b0; txn_crc_ok = 1'b0; txn_addr_hit = 1'b0;
        step();
        check("R1 kick beats tick", 1'b0, 1'b0);
        ticks(2 * STEP - 1);
        check("R1 count from zero", 1'b0, 1'b0);
        ticks(1);
        check("R1 expiry after coincident kick", 1'b1, 1'b1);
        clear();
    endtask

    task automatic t_filtered();
        ticks(3); txn(1'b0, 1'b1, 1'b0);
        ticks(1); txn(1'b1, 1'b0, 1'b0);
        ticks(1); txn(1'b1, 1'b1, 1'b1);
        ticks(2 * STEP - 6);
        check("R2 no restart before limit", 1'b0, 1'b0);
        ticks(1);
        check("R2 filtered traffic ignored", 1'b1, 1'b1);
        clear();
    endtask

    task automatic t_code_change();
        timeout_code = 4'd3; step();
        ticks(6);
        timeout_code = 4'd2; step();
        ticks(2 * STEP - 1);
        check("R7 change restarts", 1'b0, 1'b0);
        ticks(1);
        check("R7 expiry with new code", 1'b1, 1'b1);
        clear();
    endtask

    task automatic t_off();
        timeout_code = 4'd0; step();
        ticks(20 * STEP);
        check("R5 code 0 never trips", 1'b0, 1'b0);
    endtask

    task automatic t_now();
        timeout_code = 4'd15; step();
        check("R6 immediate", 1'b1, 1'b1);
        clr_fs_wr = 1'b1; step(); clr_fs_wr = 1'b0;
        check("R6 one normal cycle", 1'b0, 1'b0);
        step();
        check("R6 re-enter", 1'b1, 1'b1);
        timeout_code = 4'd0; step();
        clear();
        check("R5 R6 back to normal", 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run hung, fail_safe=%b expected finish", fail_safe);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_expire();
        t_kick();
        t_filtered();
        t_code_change();
        t_off();
        t_now();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule